// File: doc/BRIEF.md
# Quarter-Duty Multiplexed LCD Segment Driver

This block scans a multiplexed liquid-crystal panel that has four common lines and twenty segment pins. Each segment pin holds a 4-bit nibble, one bit per common, so up to eighty segments can be lit. The block does not produce analog voltages. It emits a 2-bit level code per line, and an external bias network turns that code into one of three rail levels (low, mid, high) for half-bias drive.

A frame is made of eight equal slots. Each common is selected twice per frame, once with positive polarity and once with negative polarity, so every pixel carries no net DC. The slot length is a divide of the input clock: a 75 kHz clock divided by 125 gives 600 slots per second, which is a 75 Hz frame. Software-side logic loads a digit either with data presented on the write port or with the contents of a staging register loaded earlier.

The upper eight segment pins can each be handed over to general-purpose I/O, one pin per bit. Reset and a backup (power-save) input force every line low and disable the port drivers. The slot sequence restarts from its first slot when backup is released.

Top module: `lcd_quad_drv`

## Requirements
- R1: While reset is asserted, and on the first clock edge after its release, every common and segment level is LOW (code 00), and gp_oe, gp_out and gp_in are all zero.
- R2: Every slot lasts exactly SLOT_DIV clock cycles. Slots run in the order common 0,1,2,3 at positive polarity, then common 0,1,2,3 at negative polarity, then repeat.
- R3: Level codes are LOW=00, MID=01 and HIGH=10, and code 11 never appears. Outside reset and backup, exactly one common is not MID. That active common is HIGH at positive polarity and LOW at negative polarity.
- R4: Bit k of a segment pin's nibble belongs to common k. A set bit drives the pin to the opposite level of the active common. A clear bit drives it to the same level as the active common.
- R5: A pulse of wr_en with wr_src=0 stores wr_data into the digit wr_digit, and it shows at the outputs from the next cycle. A wr_digit of NUM_SEG or more changes nothing.
- R6: ld_latch stores latch_data into a staging register. A write with wr_src=1 stores that staging value instead of wr_data.
- R7: gp_sel bit i (1 = port, 0 = segment) controls segment pin index NUM_SEG-NUM_GP+i. As a port, the pin's segment level is LOW, gp_oe[i]=gp_dir[i], gp_out[i] follows gp_dout[i] when driving, and gp_in[i] follows pad_in[i] when gp_dir[i]=0. Unselected bits give gp_oe, gp_out and gp_in of 0.
- R8: While backup is high, all levels are LOW and gp_oe, gp_out and gp_in are 0. Stored digits are kept. After release the scan starts again at common 0, positive polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup | input | 1 | Power-save force-low request |
| wr_en | input | 1 | Digit write strobe |
| wr_src | input | 1 | 0: write wr_data, 1: write staging register |
| wr_digit | input | 5 | Digit (segment pin) index |
| wr_data | input | 4 | Direct nibble |
| ld_latch | input | 1 | Load staging register |
| latch_data | input | 4 | Staging register data |
| gp_sel | input | 8 | Per-pin port select for upper pins |
| gp_dir | input | 8 | Port direction, 1 = output |
| gp_dout | input | 8 | Port output data |
| pad_in | input | 8 | Pad input values |
| com_lvl | output | 8 | Level code per common, 2 bits each |
| seg_lvl | output | 40 | Level code per segment pin, 2 bits each |
| gp_oe | output | 8 | Port output enables |
| gp_out | output | 8 | Port output values |
| gp_in | output | 8 | Port input values |

## Verification
A divider or slot counter that skips, stalls or misses a restart shows within one slot at the common outputs. The active common then appears out of order or with the wrong polarity, or a slot change lands at the wrong cycle count. A corrupted nibble, a wrong bit-to-common pairing or a wrong write select shows as a wrong segment level in the first slot whose common reads the bad bit, so a full eight-slot scan exposes it. Errors in the port mux or the force-low logic show in the same cycle at gp_oe, gp_out, gp_in or at the levels.

// File: rtl/lcd_quad_pkg.sv
package lcd_quad_pkg;
  typedef enum logic [1:0] {
    LV_LOW  = 2'b00,
    LV_MID  = 2'b01,
    LV_HIGH = 2'b10
  } lvl_e;
endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int DIV   = 125,
  parameter int SLOTS = 8,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic [SW-1:0] slot
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          tick;

  assign tick = (div_q == DW'(DIV - 1));

  always_comb begin
    div_d  = div_q;
    slot_d = slot_q;
    if (hold) begin
      div_d  = '0;
      slot_d = '0;
    end else if (tick) begin
      div_d  = '0;
      slot_d = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      div_d  = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
    end else begin
      div_q  <= div_d;
      slot_q <= slot_d;
    end
  end

  assign slot = slot_q;

  // R2: slot advances only at the end of a divide period
  a_r2_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && div_q != DW'(DIV - 1)) |=> $stable(slot_q));
  a_r2_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && div_q == DW'(DIV - 1)) |=>
      (slot_q == (($past(slot_q) == SW'(SLOTS - 1)) ? '0 : $past(slot_q) + 1'b1)));
  // R8: backup restarts the scan
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (slot_q == '0 && div_q == '0));
endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store #(
  parameter int NSEG = 20,
  parameter int BPD  = 4,
  parameter int AW   = $clog2(NSEG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_src,
  input  logic [AW-1:0]       wr_digit,
  input  logic [BPD-1:0]      wr_data,
  input  logic                ld_latch,
  input  logic [BPD-1:0]      latch_data,
  output logic [NSEG*BPD-1:0] seg_bits
);
  logic [BPD-1:0] stage_q, stage_d;
  logic [BPD-1:0] wval;

  always_comb begin
    stage_d = ld_latch ? latch_data : stage_q;
    wval    = wr_src ? stage_q : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_dig
    logic           hit;
    logic [BPD-1:0] nib_q, nib_d;
    assign hit = wr_en && (wr_digit == AW'(g));
    always_comb nib_d = hit ? wval : nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nib_q <= '0;
      else        nib_q <= nib_d;
    end
    assign seg_bits[g*BPD +: BPD] = nib_q;
  end

  // R5: direct write lands in the addressed digit
  a_r5_direct_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_src && int'(wr_digit) < NSEG) |=>
      (seg_bits[int'($past(wr_digit))*BPD +: BPD] == $past(wr_data)));
  // R5: out-of-range write touches nothing
  a_r5_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_digit) >= NSEG) |=> $stable(seg_bits));
  // R6: staged write uses the staging register
  a_r6_staged_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_src && int'(wr_digit) < NSEG) |=>
      (seg_bits[int'($past(wr_digit))*BPD +: BPD] == $past(stage_q)));
endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
  import lcd_quad_pkg::*;
#(
  parameter int NCOM = 4,
  parameter int NSEG = 20,
  parameter int CW   = $clog2(NCOM)
) (
  input  logic                 en,
  input  logic [CW:0]          slot,
  input  logic [NSEG*NCOM-1:0] seg_bits,
  input  logic [NSEG-1:0]      seg_mask,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);
  logic [CW-1:0] act;
  logic          pol;
  lvl_e          act_lvl, inv_lvl;

  assign act = slot[CW-1:0];
  assign pol = slot[CW];

  always_comb begin
    act_lvl = pol ? LV_LOW  : LV_HIGH;
    inv_lvl = pol ? LV_HIGH : LV_LOW;
  end

  for (genvar k = 0; k < NCOM; k++) begin : g_com
    always_comb begin
      if (!en)                 com_lvl[2*k +: 2] = LV_LOW;
      else if (act == CW'(k))  com_lvl[2*k +: 2] = act_lvl;
      else                     com_lvl[2*k +: 2] = LV_MID;
    end
  end

  for (genvar p = 0; p < NSEG; p++) begin : g_seg
    logic [NCOM-1:0] nib;
    assign nib = seg_bits[p*NCOM +: NCOM];
    always_comb begin
      if (!en || seg_mask[p]) seg_lvl[2*p +: 2] = LV_LOW;
      else if (nib[act])      seg_lvl[2*p +: 2] = inv_lvl;
      else                    seg_lvl[2*p +: 2] = act_lvl;
    end
  end
endmodule

// File: rtl/lcd_gpio_mux.sv
module lcd_gpio_mux #(
  parameter int NGP = 8
) (
  input  logic           en,
  input  logic [NGP-1:0] sel,
  input  logic [NGP-1:0] dir,
  input  logic [NGP-1:0] dout,
  input  logic [NGP-1:0] pad_in,
  output logic [NGP-1:0] oe,
  output logic [NGP-1:0] dout_pin,
  output logic [NGP-1:0] din
);
  for (genvar i = 0; i < NGP; i++) begin : g_pin
    always_comb begin
      oe[i]       = en & sel[i] & dir[i];
      dout_pin[i] = en & sel[i] & dir[i] & dout[i];
      din[i]      = en & sel[i] & ~dir[i] & pad_in[i];
    end
  end
endmodule

// File: rtl/lcd_quad_drv.sv
module lcd_quad_drv
  import lcd_quad_pkg::*;
#(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 20,
  parameter int NUM_GP   = 8,
  parameter int SLOT_DIV = 125,
  parameter int DIG_W    = $clog2(NUM_SEG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 backup,
  input  logic                 wr_en,
  input  logic                 wr_src,
  input  logic [DIG_W-1:0]     wr_digit,
  input  logic [NUM_COM-1:0]   wr_data,
  input  logic                 ld_latch,
  input  logic [NUM_COM-1:0]   latch_data,
  input  logic [NUM_GP-1:0]    gp_sel,
  input  logic [NUM_GP-1:0]    gp_dir,
  input  logic [NUM_GP-1:0]    gp_dout,
  input  logic [NUM_GP-1:0]    pad_in,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NUM_GP-1:0]    gp_oe,
  output logic [NUM_GP-1:0]    gp_out,
  output logic [NUM_GP-1:0]    gp_in
);
  localparam int CW      = $clog2(NUM_COM);
  localparam int SLOTS   = 2 * NUM_COM;
  localparam int GP_BASE = NUM_SEG - NUM_GP;

  logic                     run_q, run_d;
  logic                     drive;
  logic [CW:0]              slot;
  logic [NUM_SEG*NUM_COM-1:0] seg_bits;
  logic [NUM_SEG-1:0]       seg_mask;

  always_comb run_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign drive = run_q & ~backup;

  always_comb begin
    seg_mask = '0;
    seg_mask[GP_BASE +: NUM_GP] = gp_sel;
  end

  lcd_slot_timer #(.DIV(SLOT_DIV), .SLOTS(SLOTS), .SW(CW + 1)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (backup),
    .slot  (slot)
  );

  lcd_seg_store #(.NSEG(NUM_SEG), .BPD(NUM_COM), .AW(DIG_W)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_src     (wr_src),
    .wr_digit   (wr_digit),
    .wr_data    (wr_data),
    .ld_latch   (ld_latch),
    .latch_data (latch_data),
    .seg_bits   (seg_bits)
  );

  lcd_level_gen #(.NCOM(NUM_COM), .NSEG(NUM_SEG), .CW(CW)) i_levels (
    .en       (drive),
    .slot     (slot),
    .seg_bits (seg_bits),
    .seg_mask (seg_mask),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );

  lcd_gpio_mux #(.NGP(NUM_GP)) i_gpio (
    .en       (drive),
    .sel      (gp_sel),
    .dir      (gp_dir),
    .dout     (gp_dout),
    .pad_in   (pad_in),
    .oe       (gp_oe),
    .dout_pin (gp_out),
    .din      (gp_in)
  );

  // observation vectors for the port-level checks
  logic [NUM_COM-1:0] com_active;
  logic [NUM_COM-1:0] com_bad;
  logic [NUM_SEG-1:0] seg_bad;
  for (genvar k = 0; k < NUM_COM; k++) begin : g_obs_com
    assign com_active[k] = (com_lvl[2*k +: 2] != LV_MID);
    assign com_bad[k]    = (com_lvl[2*k +: 2] == 2'b11);
  end
  for (genvar p = 0; p < NUM_SEG; p++) begin : g_obs_seg
    assign seg_bad[p] = (seg_lvl[2*p +: 2] == 2'b11);
  end

  // R3: one active common while driving, no illegal code
  a_r3_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !backup) |-> $countones(com_active) == 1);
  a_r3_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
    (com_bad == '0) && (seg_bad == '0));
  // R8: backup forces all outputs low
  a_r8_backup_low: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> (com_lvl == '0 && seg_lvl == '0 && gp_oe == '0 && gp_out == '0 && gp_in == '0));
  // R7: port pins never show a segment level
  for (genvar i = 0; i < NUM_GP; i++) begin : g_chk_gp
    a_r7_port_seg_low: assert property (@(posedge clk) disable iff (!rst_n)
      gp_sel[i] |-> seg_lvl[2*(GP_BASE+i) +: 2] == LV_LOW);
    a_r7_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !gp_sel[i] |-> (!gp_oe[i] && !gp_in[i] && !gp_out[i]));
  end
endmodule

// File: tb/test_lcd_quad_drv.sv
module test_lcd_quad_drv;
  localparam int NSEG = 20;
  localparam int NCOM = 4;
  localparam int NGP  = 8;
  localparam int DIV  = 125;
  localparam int GPB  = NSEG - NGP;
  localparam logic [1:0] L_LOW = 2'b00, L_MID = 2'b01, L_HIGH = 2'b10;

  logic clk = 1'b0;
  logic rst_n, backup, wr_en, wr_src, ld_latch;
  logic [4:0] wr_digit;
  logic [3:0] wr_data, latch_data;
  logic [NGP-1:0] gp_sel, gp_dir, gp_dout, pad_in;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic [NGP-1:0] gp_oe, gp_out, gp_in;

  int checks = 0;
  int errors = 0;
  logic [3:0] shadow [NSEG];

  always #10 clk = ~clk;

  lcd_quad_drv i_lcd_quad_drv (
    .clk(clk), .rst_n(rst_n), .backup(backup),
    .wr_en(wr_en), .wr_src(wr_src), .wr_digit(wr_digit), .wr_data(wr_data),
    .ld_latch(ld_latch), .latch_data(latch_data),
    .gp_sel(gp_sel), .gp_dir(gp_dir), .gp_dout(gp_dout), .pad_in(pad_in),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .gp_oe(gp_oe), .gp_out(gp_out), .gp_in(gp_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_seg(input int p, input int k, input bit pol);
    if (p >= GPB && gp_sel[p-GPB]) return L_LOW;
    if (shadow[p][k]) return pol ? L_HIGH : L_LOW;
    return pol ? L_LOW : L_HIGH;
  endfunction

  // decode the active common and polarity from the ports, then check levels
  task automatic check_levels(output int slot_idx);
    int n_act = 0;
    int k_act = 0;
    for (int k = 0; k < NCOM; k++)
      if (com_lvl[2*k +: 2] != L_MID) begin n_act++; k_act = k; end
    chk(n_act == 1, "R3", "active common count", n_act, 1);
    chk(com_lvl[2*k_act +: 2] == L_HIGH || com_lvl[2*k_act +: 2] == L_LOW,
        "R3", "active common level", int'(com_lvl[2*k_act +: 2]), 2);
    slot_idx = ((com_lvl[2*k_act +: 2] == L_LOW) ? NCOM : 0) + k_act;
    for (int p = 0; p < NSEG; p++) begin
      logic [1:0] e;
      e = exp_seg(p, k_act, com_lvl[2*k_act +: 2] == L_LOW);
      chk(seg_lvl[2*p +: 2] == e, "R4", $sformatf("seg pin %0d", p),
          int'(seg_lvl[2*p +: 2]), int'(e));
    end
  endtask

  task automatic wait_change(output int cycles);
    logic [2*NCOM-1:0] prev;
    prev = com_lvl;
    cycles = 0;
    for (int n = 1; n <= 2*DIV; n++) begin
      @(negedge clk);
      if (com_lvl != prev) begin cycles = n; break; end
    end
    if (cycles == 0) chk(1'b0, "R2", "no slot change", 0, DIV);
  endtask

  task automatic scan_frame();
    int c, s;
    for (int i = 0; i < 2*NCOM; i++) begin
      wait_change(c);
      check_levels(s);
    end
  endtask

  task automatic write_digit(input int d, input logic [3:0] v, input bit via_stage);
    @(negedge clk);
    wr_en = 1'b1; wr_src = via_stage; wr_digit = 5'(d); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_src = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(com_lvl == '0, "R1", "com in reset", int'(com_lvl), 0);
    chk(seg_lvl == '0, "R1", "seg in reset", 0, 0);
    chk(gp_oe == '0 && gp_out == '0 && gp_in == '0, "R1", "ports in reset",
        int'(gp_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(com_lvl == {L_MID, L_MID, L_MID, L_HIGH}, "R1", "first slot common 0 positive",
        int'(com_lvl), int'({L_MID, L_MID, L_MID, L_HIGH}));
  endtask

  task automatic test_timing();
    int c, s, prev_s;
    wait_change(c);
    check_levels(prev_s);
    for (int i = 0; i < 2*NCOM + 2; i++) begin
      wait_change(c);
      chk(c == DIV, "R2", "slot length", c, DIV);
      check_levels(s);
      chk(s == (prev_s + 1) % (2*NCOM), "R2", "slot order", s, (prev_s + 1) % (2*NCOM));
      prev_s = s;
    end
  endtask

  task automatic test_patterns();
    for (int d = 0; d < NSEG; d++) begin write_digit(d, 4'hF, 1'b0); shadow[d] = 4'hF; end
    scan_frame();
    for (int d = 0; d < NSEG; d++) begin
      write_digit(d, 4'(d * 7 + 3), 1'b0); shadow[d] = 4'(d * 7 + 3);
    end
    scan_frame();
    write_digit(5, 4'h0, 1'b0); shadow[5] = 4'h0;
    write_digit(19, 4'h9, 1'b0); shadow[19] = 4'h9;
    scan_frame();
  endtask

  task automatic test_out_of_range();
    write_digit(20, 4'h6, 1'b0);
    write_digit(31, 4'hC, 1'b0);
    scan_frame();   // R5: shadow unchanged, so any effect shows as a mismatch
  endtask

  task automatic test_stage();
    @(negedge clk);
    ld_latch = 1'b1; latch_data = 4'hA;
    @(negedge clk);
    ld_latch = 1'b0; latch_data = 4'h3;
    @(negedge clk);
    wr_data = 4'h5;
    write_digit(3, 4'h5, 1'b1); shadow[3] = 4'hA;   // R6
    write_digit(17, 4'h1, 1'b1); shadow[17] = 4'hA; // R6
    scan_frame();
  endtask

  task automatic test_gpio();
    @(negedge clk);
    gp_sel = 8'b1010_0110; gp_dir = 8'b1000_0100; gp_dout = 8'hFF; pad_in = 8'hFF;
    @(negedge clk);
    chk(gp_oe == (gp_sel & gp_dir), "R7", "gp_oe", int'(gp_oe), int'(gp_sel & gp_dir));
    chk(gp_out == (gp_sel & gp_dir), "R7", "gp_out", int'(gp_out), int'(gp_sel & gp_dir));
    chk(gp_in == (gp_sel & ~gp_dir), "R7", "gp_in", int'(gp_in), int'(gp_sel & ~gp_dir));
    gp_dout = 8'h00; pad_in = 8'h00;
    @(negedge clk);
    chk(gp_out == 8'h00 && gp_in == 8'h00, "R7", "port data follows", int'(gp_out | gp_in), 0);
    scan_frame();   // R7: selected pins LOW
    gp_sel = 8'h00;
    @(negedge clk);
    chk(gp_oe == 8'h00, "R7", "gp_oe deselected", int'(gp_oe), 0);
  endtask

  task automatic test_backup();
    int c, s;
    gp_sel = 8'hFF; gp_dir = 8'h0F; gp_dout = 8'hFF; pad_in = 8'hFF;
    repeat (40) @(negedge clk);
    backup = 1'b1;
    @(negedge clk);
    chk(com_lvl == '0 && seg_lvl == '0, "R8", "levels in backup", int'(com_lvl), 0);
    chk(gp_oe == '0 && gp_out == '0 && gp_in == '0, "R8", "ports in backup",
        int'(gp_oe | gp_out | gp_in), 0);
    repeat (300) @(negedge clk);
    chk(com_lvl == '0, "R8", "levels stay low", int'(com_lvl), 0);
    gp_sel = 8'h00;
    backup = 1'b0;
    @(negedge clk);
    chk(com_lvl == {L_MID, L_MID, L_MID, L_HIGH}, "R8", "restart at common 0 positive",
        int'(com_lvl), int'({L_MID, L_MID, L_MID, L_HIGH}));
    check_levels(s);   // R8: stored digits kept
    wait_change(c);
    chk(c >= DIV - 1 && c <= DIV, "R8", "first slot after release", c, DIV);
    scan_frame();
  endtask

  initial begin
    rst_n = 1'b0; backup = 1'b0; wr_en = 1'b0; wr_src = 1'b0; ld_latch = 1'b0;
    wr_digit = '0; wr_data = '0; latch_data = '0;
    gp_sel = '0; gp_dir = '0; gp_dout = '0; pad_in = '0;
    for (int d = 0; d < NSEG; d++) shadow[d] = 4'h0;
    test_reset();
    test_timing();
    test_patterns();
    test_out_of_range();
    test_stage();
    test_gpio();
    test_backup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule